// File: doc/BRIEF.md
# Parallel RGB Panel Timing Generator

This block produces the line and frame timing for a parallel 24-bit RGB panel driven by a pixel clock. A horizontal counter runs over a programmable number of pixel clocks per line. A vertical counter advances once per completed line and runs over a programmable number of lines per frame. From these two counts the block decodes the active-low sync pulses, an active-high data enable, and the pixel and line position inside the visible window. Separate horizontal and vertical wait counts place that window after the start of the line and the frame.

While data enable is high, the block strobes a pixel request toward an upstream pixel source and passes that source's pixel word through to the panel. Outside the window the word is forced to zero. If the source signals an underflow during an active pixel, the block does not stall. It blanks the rest of the frame while the sync pulses keep running, then resumes clean output at the next frame start. The configuration comes in on plain input ports, which must be held stable whenever the block is disabled and then enabled.

Top module: `rgb_panel_timing`

## Requirements
- R1: While `enable` is low, `hsync_n` and `vsync_n` are 1 and `de`, `pix_req` and `frame_start` are 0. Both counters are cleared, so the first enabled clock is pixel 0 of line 0.
- R2: The horizontal count runs from 0 to `cfg_h_period`-1 in pixel clocks, then wraps. `hsync_n` is 0 exactly while the count is below `cfg_h_pulse`.
- R3: The line count advances when the horizontal count wraps and runs from 0 to `cfg_v_period`-1 lines. `vsync_n` is 0 exactly while the line count is below `cfg_v_pulse`.
- R4: `de` is 1 exactly when the horizontal count h satisfies `cfg_h_wait` <= h < `cfg_h_wait`+`cfg_h_active`, the line count v satisfies `cfg_v_wait` <= v < `cfg_v_wait`+`cfg_v_active`, and the frame is not blanked.
- R5: `pix_req` is 1 in exactly the clocks where `de` is 1, giving one request per active pixel.
- R6: While `de` is 1, `pix_x` = h - `cfg_h_wait` and `pix_y` = v - `cfg_v_wait`. Otherwise both are 0.
- R7: `frame_start` is 1 for the single clock in which h = 0 and v = 0 while enabled.
- R8: `pix_out` equals `pix_in` while `de` is 1 and is all zeros otherwise.
- R9: `pix_underflow` high in a clock where `de` is 1 blanks `de` from the next clock to the end of the frame. The sync outputs continue unchanged, and the following frame is output normally.
- R10: `pix_underflow` high in a clock where `de` is 0 has no effect on the output.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the timing; low idles and clears the counters |
| cfg_h_period | input | HW | Pixel clocks per line |
| cfg_h_pulse | input | HW | Hsync width in pixel clocks |
| cfg_h_wait | input | HW | Pixel clocks from line start to the first active pixel |
| cfg_h_active | input | HW | Active pixels per line |
| cfg_v_period | input | VW | Lines per frame |
| cfg_v_pulse | input | VW | Vsync width in lines |
| cfg_v_wait | input | VW | Lines from frame start to the first active line |
| cfg_v_active | input | VW | Active lines per frame |
| pix_in | input | DW | Pixel word from the upstream source |
| pix_underflow | input | 1 | Source could not supply the requested pixel |
| hsync_n | output | 1 | Horizontal sync, active low |
| vsync_n | output | 1 | Vertical sync, active low |
| de | output | 1 | Data enable, active high |
| pix_req | output | 1 | Pixel request strobe to the source |
| frame_start | output | 1 | One-clock pulse at pixel 0 of line 0 |
| pix_x | output | HW | Pixel index inside the active window |
| pix_y | output | VW | Line index inside the active window |
| pix_out | output | DW | Pixel word to the panel |

## Verification
Underflow blanking and the frame wrap can land on the same clock. An underflow on the last pixel of a frame that is fully active must leave the next frame untouched, because the wrap clears the blank before the blank can take effect. A second configuration with zero wait counts and a window that fills the whole frame provokes this case. It also lets the active window overlap both sync pulses. Every clock is compared against counts derived arithmetically from the elapsed cycle index and a model blank flag. An underflow placed on a blanked clock is checked to change nothing.

// File: rtl/ptg_pkg.sv
package ptg_pkg;

    // Decode of one axis: inside the sync pulse, inside the active window
    typedef struct packed {
        logic in_pulse;
        logic in_window;
    } ptg_span_t;

    // Registered control state of the top level
    typedef struct packed {
        logic blank;
    } ptg_ctl_t;

endpackage

// File: rtl/ptg_axis.sv
module ptg_axis #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         step,
    input  logic [W-1:0] period,
    output logic [W-1:0] count,
    output logic         wrap
);
    logic [W-1:0] cnt_d, cnt_q;
    logic         at_end;

    always_comb begin
        at_end = (cnt_q >= (period - 1'b1));
        wrap   = step && at_end;
        cnt_d  = cnt_q;
        if (clear) begin
            cnt_d = '0;
        end else if (step) begin
            cnt_d = at_end ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count = cnt_q;
endmodule

// File: rtl/ptg_span.sv
module ptg_span
    import ptg_pkg::*;
#(
    parameter int W = 12
) (
    input  logic [W-1:0] pos,
    input  logic [W-1:0] pulse,
    input  logic [W-1:0] wait_cnt,
    input  logic [W-1:0] active,
    output ptg_span_t    span,
    output logic [W-1:0] offset
);
    localparam int EW = W + 1;

    logic [EW-1:0] pos_e, wait_e, act_e, diff_e;
    logic          past_wait;

    always_comb begin
        pos_e          = {1'b0, pos};
        wait_e         = {1'b0, wait_cnt};
        act_e          = {1'b0, active};
        diff_e         = pos_e - wait_e;
        past_wait      = (pos_e >= wait_e);
        span.in_pulse  = (pos < pulse);
        span.in_window = past_wait && (diff_e < act_e);
        offset         = span.in_window ? diff_e[W-1:0] : '0;
    end
endmodule

// File: rtl/rgb_panel_timing.sv
module rgb_panel_timing
    import ptg_pkg::*;
#(
    parameter int HW = 12,
    parameter int VW = 11,
    parameter int DW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic [HW-1:0] cfg_h_period,
    input  logic [HW-1:0] cfg_h_pulse,
    input  logic [HW-1:0] cfg_h_wait,
    input  logic [HW-1:0] cfg_h_active,
    input  logic [VW-1:0] cfg_v_period,
    input  logic [VW-1:0] cfg_v_pulse,
    input  logic [VW-1:0] cfg_v_wait,
    input  logic [VW-1:0] cfg_v_active,
    input  logic [DW-1:0] pix_in,
    input  logic          pix_underflow,
    output logic          hsync_n,
    output logic          vsync_n,
    output logic          de,
    output logic          pix_req,
    output logic          frame_start,
    output logic [HW-1:0] pix_x,
    output logic [VW-1:0] pix_y,
    output logic [DW-1:0] pix_out
);
    logic [HW-1:0] h_cnt, h_off;
    logic [VW-1:0] v_cnt, v_off;
    logic          h_wrap, v_wrap, frame_wrap;
    ptg_span_t     h_span, v_span;
    ptg_ctl_t      st_d, st_q;

    ptg_axis #(.W(HW)) u_h_axis (
        .clk(clk), .rst_n(rst_n), .clear(!enable), .step(enable),
        .period(cfg_h_period), .count(h_cnt), .wrap(h_wrap)
    );

    ptg_axis #(.W(VW)) u_v_axis (
        .clk(clk), .rst_n(rst_n), .clear(!enable), .step(h_wrap),
        .period(cfg_v_period), .count(v_cnt), .wrap(v_wrap)
    );

    ptg_span #(.W(HW)) u_h_span (
        .pos(h_cnt), .pulse(cfg_h_pulse), .wait_cnt(cfg_h_wait),
        .active(cfg_h_active), .span(h_span), .offset(h_off)
    );

    ptg_span #(.W(VW)) u_v_span (
        .pos(v_cnt), .pulse(cfg_v_pulse), .wait_cnt(cfg_v_wait),
        .active(cfg_v_active), .span(v_span), .offset(v_off)
    );

    always_comb begin
        frame_wrap  = h_wrap && v_wrap;
        de          = enable && h_span.in_window && v_span.in_window && !st_q.blank;
        pix_req     = de;
        hsync_n     = !(enable && h_span.in_pulse);
        vsync_n     = !(enable && v_span.in_pulse);
        frame_start = enable && (h_cnt == '0) && (v_cnt == '0);
        pix_x       = de ? h_off : '0;
        pix_y       = de ? v_off : '0;
        pix_out     = de ? pix_in : '0;

        // frame wrap wins over a same-cycle underflow
        st_d = st_q;
        if (!enable || frame_wrap) begin
            st_d.blank = 1'b0;
        end else if (de && pix_underflow) begin
            st_d.blank = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/ptg_checker.sv
module ptg_checker #(
    parameter int HW = 12,
    parameter int VW = 11,
    parameter int DW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          enable,
    input logic [HW-1:0] cfg_h_pulse,
    input logic [HW-1:0] cfg_h_active,
    input logic [VW-1:0] cfg_v_pulse,
    input logic [VW-1:0] cfg_v_active,
    input logic          pix_underflow,
    input logic          hsync_n,
    input logic          vsync_n,
    input logic          de,
    input logic          frame_start,
    input logic [HW-1:0] pix_x,
    input logic [VW-1:0] pix_y,
    input logic [DW-1:0] pix_out
);
    // R1
    idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> (hsync_n && vsync_n && !de && !frame_start));

    // R9
    blank_after_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (de && pix_underflow) |=> (!de || frame_start));

    // R6
    pos_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> ((pix_x < cfg_h_active) && (pix_y < cfg_v_active)));

    // R8
    out_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !de |-> (pix_out == '0));

    // R7
    start_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && cfg_h_pulse != '0 && cfg_v_pulse != '0) |-> (!hsync_n && !vsync_n));
endmodule

bind rgb_panel_timing ptg_checker #(.HW(HW), .VW(VW), .DW(DW)) u_ptg_checker (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .cfg_h_pulse(cfg_h_pulse), .cfg_h_active(cfg_h_active),
    .cfg_v_pulse(cfg_v_pulse), .cfg_v_active(cfg_v_active),
    .pix_underflow(pix_underflow), .hsync_n(hsync_n), .vsync_n(vsync_n),
    .de(de), .frame_start(frame_start), .pix_x(pix_x), .pix_y(pix_y),
    .pix_out(pix_out)
);

// File: tb/rgb_panel_timing_test.sv
module rgb_panel_timing_test;
    localparam int HW = 12;
    localparam int VW = 11;
    localparam int DW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic [HW-1:0] cfg_h_period, cfg_h_pulse, cfg_h_wait, cfg_h_active;
    logic [VW-1:0] cfg_v_period, cfg_v_pulse, cfg_v_wait, cfg_v_active;
    logic [DW-1:0] pix_in = '0;
    logic          pix_underflow = 1'b0;
    logic          hsync_n, vsync_n, de, pix_req, frame_start;
    logic [HW-1:0] pix_x;
    logic [VW-1:0] pix_y;
    logic [DW-1:0] pix_out;

    int n_checks = 0;
    int n_fail   = 0;
    int t;
    bit mblank;

    always #4 clk = ~clk;

    rgb_panel_timing #(.HW(HW), .VW(VW), .DW(DW)) uut (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .cfg_h_period(cfg_h_period), .cfg_h_pulse(cfg_h_pulse),
        .cfg_h_wait(cfg_h_wait), .cfg_h_active(cfg_h_active),
        .cfg_v_period(cfg_v_period), .cfg_v_pulse(cfg_v_pulse),
        .cfg_v_wait(cfg_v_wait), .cfg_v_active(cfg_v_active),
        .pix_in(pix_in), .pix_underflow(pix_underflow),
        .hsync_n(hsync_n), .vsync_n(vsync_n), .de(de), .pix_req(pix_req),
        .frame_start(frame_start), .pix_x(pix_x), .pix_y(pix_y), .pix_out(pix_out)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s t=%0d actual=%0h expected=%0h", req, t, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    task automatic set_cfg(input int hp, input int hpw, input int hwt, input int ha,
                           input int vp, input int vpw, input int vwt, input int va);
        cfg_h_period = HW'(hp); cfg_h_pulse = HW'(hpw);
        cfg_h_wait   = HW'(hwt); cfg_h_active = HW'(ha);
        cfg_v_period = VW'(vp); cfg_v_pulse = VW'(vpw);
        cfg_v_wait   = VW'(vwt); cfg_v_active = VW'(va);
    endtask

    task automatic check_idle(input string tag);
        check(hsync_n === 1'b1 && vsync_n === 1'b1, {"R1 sync idle ", tag}, {hsync_n, vsync_n}, 3);
        check(de === 1'b0 && pix_req === 1'b0 && frame_start === 1'b0,
              {"R1 de/req/start idle ", tag}, {de, pix_req, frame_start}, 0);
    endtask

    // Called at a negedge with enable low; runs n cycles from a fresh frame
    task automatic run(input int n, input int uf_a, input int uf_b);
        int hp, vp, h, v;
        bit inh, inv, e_de, uf;
        hp = int'(cfg_h_period);
        vp = int'(cfg_v_period);
        enable = 1'b1;
        mblank = 1'b0;
        t = 0;
        while (t < n) begin
            h    = t % hp;
            v    = (t / hp) % vp;
            inh  = (h >= int'(cfg_h_wait)) && (h < int'(cfg_h_wait) + int'(cfg_h_active));
            inv  = (v >= int'(cfg_v_wait)) && (v < int'(cfg_v_wait) + int'(cfg_v_active));
            e_de = inh && inv && !mblank;
            uf   = (t == uf_a) || (t == uf_b);
            pix_underflow = uf;
            pix_in = DW'(32'h5A0000 + t);
            #1;
            check(hsync_n === !(h < int'(cfg_h_pulse)), "R2 hsync_n", hsync_n, !(h < int'(cfg_h_pulse)));
            check(vsync_n === !(v < int'(cfg_v_pulse)), "R3 vsync_n", vsync_n, !(v < int'(cfg_v_pulse)));
            check(de === e_de, "R4 R9 R10 de", de, e_de);
            check(pix_req === e_de, "R5 pix_req", pix_req, e_de);
            check(pix_x === (e_de ? HW'(h - int'(cfg_h_wait)) : HW'(0)), "R6 pix_x", pix_x,
                  e_de ? h - int'(cfg_h_wait) : 0);
            check(pix_y === (e_de ? VW'(v - int'(cfg_v_wait)) : VW'(0)), "R6 pix_y", pix_y,
                  e_de ? v - int'(cfg_v_wait) : 0);
            check(frame_start === (h == 0 && v == 0), "R7 frame_start", frame_start, h == 0 && v == 0);
            check(pix_out === (e_de ? pix_in : DW'(0)), "R8 pix_out", pix_out, e_de ? pix_in : 0);
            if ((t + 1) % (hp * vp) == 0) mblank = 1'b0;
            else if (e_de && uf)          mblank = 1'b1;
            @(negedge clk);
            t++;
        end
        pix_underflow = 1'b0;
        enable = 1'b0;
        #1;
        check_idle("after run");
        @(negedge clk);
        @(negedge clk);
        #1;
        check_idle("held off");
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        set_cfg(10, 2, 3, 4, 7, 1, 2, 3);
        repeat (3) @(negedge clk);
        t = 0;
        #1;
        check_idle("in reset");
        rst_n = 1'b1;
        @(negedge clk);
        // R2 R3 R4: two clean frames, window away from sync
        run(140, -1, -1);
        // R10: underflow on a blank clock of line 0; R9: underflow mid-window
        run(140, 5, -1);
        run(140, 24, -1);
        // R9 R10: window spans the whole frame and overlaps both syncs
        set_cfg(8, 3, 0, 8, 5, 2, 0, 5);
        run(80, 12, 30);
        // R9: underflow on the final pixel coincides with the frame wrap
        run(80, 39, -1);
        // R4 R6: window ends exactly at line and frame end
        set_cfg(9, 1, 5, 4, 6, 3, 4, 2);
        run(108, 50, -1);
        summary();
    end
endmodule